// File: doc/BRIEF.md
# Interlaced Field Weaving Frame Writer

This block sits between a clock-crossing line FIFO and a frame buffer held in synchronous SRAM. Camera video arrives as two interlaced fields, the odd field first and the even field second. The block moves each line from the FIFO into the frame buffer so that the two fields end up woven into one progressive frame. Odd-field lines fill the even-numbered frame rows (0, 2, 4, …). Even-field lines fill the odd-numbered frame rows (1, 3, 5, …).

The block waits until the FIFO holds a whole line. The FIFO shows this by raising its full flag while its empty flag is low. The block then reads the line at one word per cycle and writes each word to SRAM at frame row times line width plus column. A pulse on `field_start`, qualified by `field_even`, marks the start of each field. An even field that does not follow a completed odd field is drained from the FIFO and dropped, so a frame never mixes fields from different frames. `frame_done` pulses once for each frame that is woven completely.

Top module: `field_weave_writer`

## Requirements
- R1: No FIFO read starts unless the FIFO full flag is high and the empty flag is low in the cycle before the first read, so a partial line is never taken.
- R2: Each line transfer reads exactly LINE_W words on consecutive cycles (`fifo_rd_en` high for LINE_W cycles), then the block returns to idle.
- R3: Line k (counting from 0) of an accepted odd field (`field_even`=0 at `field_start`) is written to frame row 2k, at SRAM addresses 2k·LINE_W + column.
- R4: Line k of an accepted even field (`field_even`=1) is written to frame row 2k+1, at addresses (2k+1)·LINE_W + column. Its first write therefore goes to address LINE_W.
- R5: The words written to a row equal the FIFO words of that line in read order. Each SRAM write appears two cycles after its FIFO read.
- R6: `frame_done` is high for exactly one cycle, in the cycle after the last SRAM write of the final line of an accepted even field.
- R7: An even field whose start is not preceded by a completed odd field (FIELD_LINES lines written since the last odd `field_start`) is read from the FIFO but produces no SRAM writes and no `frame_done`.
- R8: Lines received after FIELD_LINES lines of a field have been written are read from the FIFO and produce no SRAM writes.
- R9: A new odd `field_start` restarts the weave. An even field that ends before its FIELD_LINES lines are written produces no `frame_done`.
- R10: A `field_start` that arrives while a line is being read takes effect after that line ends. That line is still written to the row of the field it belongs to.
- R11: After reset, `fifo_rd_en`, `sram_we` and `frame_done` are low, and no field is accepted until an odd `field_start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_full | input | 1 | FIFO holds at least one complete line |
| fifo_empty | input | 1 | FIFO holds no words |
| fifo_rd_en | output | 1 | FIFO read strobe, one word per cycle |
| fifo_rdata | input | DATA_W | FIFO read data, valid the cycle after a read |
| field_start | input | 1 | One-cycle pulse marking the start of a field |
| field_even | input | 1 | Field parity sampled with `field_start`: 0 odd, 1 even |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM word address, row·LINE_W + column |
| sram_wdata | output | DATA_W | SRAM write data |
| frame_done | output | 1 | One-cycle pulse after a full frame is woven |

## Verification
The hardest situation to reach from the ports is a field boundary that falls on the final line of the odd field while that line is still being read. If the boundary is applied too early, the last odd line lands in an even row, or the even field is dropped as an orphan. To reach it, the bench loads the fourth odd line and waits until the reads are under way. It then pulses an even `field_start` in the middle of the transfer and checks both the row of that last odd line and the frame completion that follows. A vector table also sends fields in orders that break the odd-then-even rule: orphan evens, short odd fields, over-long fields and partial evens.

// File: rtl/fw_pkg.sv
package fw_pkg;

  // Line transfer state.
  typedef enum logic {
    LC_IDLE = 1'b0,
    LC_XFER = 1'b1
  } lc_state_t;

  // Field parity as carried on field_even.
  typedef enum logic {
    FLD_ODD  = 1'b0,
    FLD_EVEN = 1'b1
  } fld_kind_t;

endpackage

// File: rtl/fw_line_ctrl.sv
// Line transfer sequencer: waits for a whole line in the FIFO, then
// reads LINE_W words back to back and exposes the column index.
module fw_line_ctrl
  import fw_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int COL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output logic             rd_en,
  output logic [COL_W-1:0] col,
  output logic             line_end
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_W - 1);

  lc_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LC_IDLE;
      col   <= '0;
    end else begin
      case (state)
        LC_IDLE: begin
          if (fifo_full && !fifo_empty) begin
            state <= LC_XFER;
            col   <= '0;
          end
        end
        LC_XFER: begin
          if (col == COL_LAST) begin
            state <= LC_IDLE;
            col   <= '0;
          end else begin
            col <= col + COL_W'(1);
          end
        end
        default: state <= LC_IDLE;
      endcase
    end
  end

  assign rd_en    = (state == LC_XFER);
  assign line_end = rd_en && (col == COL_LAST);

  // R1: a read burst only begins after the FIFO reported a full line.
  a_r1_start_on_line: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(fifo_full && !fifo_empty));

  // R2: the burst stops right after the last column.
  a_r2_burst_stops: assert property (@(posedge clk) disable iff (rst)
    line_end |=> !rd_en);

  // R2: the burst is unbroken until the last column.
  a_r2_burst_contiguous: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !line_end) |=> rd_en);

endmodule

// File: rtl/fw_field_track.sv
// Field bookkeeping: decides whether the current line is kept, tracks
// the woven row base and flags the last line of a complete frame.
module fw_field_track
  import fw_pkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int FIELD_LINES = 4,
  parameter int BASE_W      = 8,
  parameter int LCNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_start,
  input  logic              field_even,
  input  logic              busy,
  input  logic              line_end,
  output logic              line_keep,
  output logic [BASE_W-1:0] row_base,
  output logic              frame_end
);

  localparam logic [BASE_W-1:0] ROW_STEP  = BASE_W'(2 * LINE_W);
  localparam logic [BASE_W-1:0] EVEN_BASE = BASE_W'(LINE_W);
  localparam logic [LCNT_W-1:0] LINES_MAX = LCNT_W'(FIELD_LINES);
  localparam logic [LCNT_W-1:0] ONE_LEFT  = LCNT_W'(1);

  logic              odd_done;
  fld_kind_t         cur_kind;
  logic [LCNT_W-1:0] lines_left;
  logic              pend_v;
  fld_kind_t         pend_kind;
  logic              start_now;
  fld_kind_t         start_kind;

  assign start_now  = !busy && (field_start || pend_v);
  assign start_kind = field_start ? fld_kind_t'(field_even) : pend_kind;
  assign line_keep  = (lines_left != '0);
  assign frame_end  = line_end && line_keep && (cur_kind == FLD_EVEN) &&
                      (lines_left == ONE_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_done   <= 1'b0;
      cur_kind   <= FLD_ODD;
      lines_left <= '0;
      row_base   <= '0;
      pend_v     <= 1'b0;
      pend_kind  <= FLD_ODD;
    end else begin
      // A field start seen mid-line waits for the line to finish.
      if (busy && field_start) begin
        pend_v    <= 1'b1;
        pend_kind <= fld_kind_t'(field_even);
      end else if (start_now) begin
        pend_v <= 1'b0;
      end

      if (start_now) begin
        if (start_kind == FLD_ODD) begin
          cur_kind   <= FLD_ODD;
          lines_left <= LINES_MAX;
          row_base   <= '0;
          odd_done   <= 1'b0;
        end else if (odd_done) begin
          cur_kind   <= FLD_EVEN;
          lines_left <= LINES_MAX;
          row_base   <= EVEN_BASE;
          odd_done   <= 1'b0;
        end else begin
          // Orphan even field: drain it without writing.
          cur_kind   <= FLD_EVEN;
          lines_left <= '0;
          odd_done   <= 1'b0;
        end
      end else if (line_end && line_keep) begin
        lines_left <= lines_left - ONE_LEFT;
        row_base   <= row_base + ROW_STEP;
        if ((lines_left == ONE_LEFT) && (cur_kind == FLD_ODD)) begin
          odd_done <= 1'b1;
        end
      end
    end
  end

  // R7: an even start with no finished odd field keeps nothing.
  a_r7_orphan_dropped: assert property (@(posedge clk) disable iff (rst)
    (start_now && (start_kind == FLD_EVEN) && !odd_done) |=> !line_keep);

  // R8: the kept-line budget never exceeds one field.
  a_r8_budget_bounded: assert property (@(posedge clk) disable iff (rst)
    lines_left <= LINES_MAX);

  // R10: row base never moves while a line is in flight except at its end.
  a_r10_base_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(line_end)) |-> $stable(row_base));

endmodule

// File: rtl/fw_write_stage.sv
// Aligns FIFO read data with its address and drives the SRAM port and
// the frame completion pulse, all from registers.
module fw_write_stage #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              keep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              last,
  input  logic [DATA_W-1:0] rdata,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              frame_done
);

  logic              s1_we;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_last;
  logic              s2_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_we      <= 1'b0;
      s1_addr    <= '0;
      s1_last    <= 1'b0;
      s2_last    <= 1'b0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
      frame_done <= 1'b0;
    end else begin
      s1_we      <= rd_en && keep;
      s1_addr    <= addr;
      s1_last    <= rd_en && last;
      sram_we    <= s1_we;
      sram_addr  <= s1_addr;
      sram_wdata <= rdata;
      s2_last    <= s1_last;
      frame_done <= s2_last;
    end
  end

  // R5: every SRAM write traces back to a FIFO read two cycles earlier.
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> $past(rd_en, 2));

  // R6: frame completion is a single-cycle pulse.
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R6: frame completion follows a write in the previous cycle.
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(sram_we));

endmodule

// File: rtl/field_weave_writer.sv
// Top: weaves two interlaced fields from a line FIFO into one frame.
module field_weave_writer #(
  parameter int DATA_W      = 16,
  parameter int LINE_W      = 16,
  parameter int FIELD_LINES = 4,
  localparam int FRAME_WORDS = 2 * FIELD_LINES * LINE_W,
  localparam int ADDR_W      = $clog2(FRAME_WORDS),
  localparam int COL_W       = (LINE_W > 1) ? $clog2(LINE_W) : 1,
  localparam int LCNT_W      = $clog2(FIELD_LINES + 1),
  localparam int BASE_W      = $clog2(FRAME_WORDS + 2 * LINE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic              field_start,
  input  logic              field_even,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              frame_done
);

  logic [COL_W-1:0]  col;
  logic              line_end;
  logic              line_keep;
  logic [BASE_W-1:0] row_base;
  logic              frame_end;
  logic [BASE_W-1:0] word_addr;

  fw_line_ctrl #(
    .LINE_W (LINE_W),
    .COL_W  (COL_W)
  ) u_line (
    .clk        (clk),
    .rst        (rst),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .rd_en      (fifo_rd_en),
    .col        (col),
    .line_end   (line_end)
  );

  fw_field_track #(
    .LINE_W      (LINE_W),
    .FIELD_LINES (FIELD_LINES),
    .BASE_W      (BASE_W),
    .LCNT_W      (LCNT_W)
  ) u_field (
    .clk         (clk),
    .rst         (rst),
    .field_start (field_start),
    .field_even  (field_even),
    .busy        (fifo_rd_en),
    .line_end    (line_end),
    .line_keep   (line_keep),
    .row_base    (row_base),
    .frame_end   (frame_end)
  );

  assign word_addr = row_base + BASE_W'(col);

  fw_write_stage #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_write (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (fifo_rd_en),
    .keep       (line_keep),
    .addr       (word_addr[ADDR_W-1:0]),
    .last       (frame_end),
    .rdata      (fifo_rdata),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .frame_done (frame_done)
  );

endmodule

// File: tb/field_weave_writer_tb.sv
module field_weave_writer_tb;

  localparam int DW = 16;
  localparam int LW = 16;
  localparam int FL = 4;
  localparam int AW = 7;

  // Vector: [7] even, [6:4] lines sent, [3:1] lines expected kept, [0] frame done.
  localparam logic [7:0] VEC [9] = '{
    8'b0_100_100_0,  // odd full                      R3
    8'b1_100_100_1,  // even after odd -> frame       R4 R6
    8'b1_100_000_0,  // orphan even                   R7
    8'b0_010_010_0,  // short odd                     R3
    8'b1_100_000_0,  // even after short odd dropped  R7
    8'b0_101_100_0,  // odd with extra line           R8
    8'b1_011_011_0,  // partial even                  R9
    8'b0_100_100_0,  // odd restart                   R9
    8'b1_100_100_1   // even -> frame                 R4 R6
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_full, fifo_empty, fifo_rd_en;
  logic [DW-1:0] fifo_rdata = '0;
  logic          field_start = 1'b0;
  logic          field_even = 1'b0;
  logic          sram_we, frame_done;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  field_weave_writer #(.DATA_W(DW), .LINE_W(LW), .FIELD_LINES(FL)) u_dut (
    .clk(clk), .rst(rst), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_rd_en(fifo_rd_en), .fifo_rdata(fifo_rdata),
    .field_start(field_start), .field_even(field_even),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .frame_done(frame_done)
  );

  // FIFO model: full means a whole line is present.
  logic [DW-1:0] fmem [64];
  int wp = 0;
  int rp = 0;
  assign fifo_full  = (wp - rp) >= LW;
  assign fifo_empty = (wp == rp);

  always @(posedge clk) begin
    if (fifo_rd_en) begin
      fifo_rdata <= fmem[rp % 64];
      rp <= rp + 1;
    end
  end

  // SRAM model and port monitor.
  logic [DW-1:0] sram [128];
  int cyc = 0;
  int wr_cnt = 0, done_cnt = 0, rd_cnt = 0;
  int done_cyc = -1, last_we_cyc = -1, first_rd_cyc = -1, last_rd_cyc = -1;
  int first_addr = -1;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (sram_we) begin
      sram[sram_addr] <= sram_wdata;
      if (wr_cnt == 0) first_addr = int'(sram_addr);
      wr_cnt = wr_cnt + 1;
      last_we_cyc = cyc;
    end
    if (frame_done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
    if (fifo_rd_en) begin
      if (rd_cnt == 0) first_rd_cyc = cyc;
      rd_cnt = rd_cnt + 1;
      last_rd_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    wr_cnt = 0; done_cnt = 0; rd_cnt = 0;
    done_cyc = -1; last_we_cyc = -1; first_addr = -1;
    first_rd_cyc = -1; last_rd_cyc = -1;
  endtask

  function automatic logic [DW-1:0] pix(input int step, input int ev, input int ln, input int c);
    return {4'(step), 1'(ev), 3'(ln), 8'(c)};
  endfunction

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge clk);
    fmem[wp % 64] = d;
    wp = wp + 1;
  endtask

  task automatic start_field(input bit ev);
    @(negedge clk);
    field_start = 1'b1;
    field_even = ev;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic send_line(input int step, input int ev, input int ln);
    for (int c = 0; c < LW; c++) push_word(pix(step, ev, ln, c));
    repeat (LW + 6) @(negedge clk);
  endtask

  function automatic int row_errors(input int step, input int ev, input int ln);
    int e = 0;
    for (int c = 0; c < LW; c++)
      if (sram[(2 * ln + ev) * LW + c] !== pix(step, ev, ln, c)) e++;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(fifo_rd_en == 1'b0, "R11 rd_en in reset", int'(fifo_rd_en), 0);
    chk(sram_we == 1'b0, "R11 we in reset", int'(sram_we), 0);
    chk(frame_done == 1'b0, "R11 done in reset", int'(frame_done), 0);
    rst = 1'b0;

    // R11: lines before any field start are drained, not written.
    clear_mon();
    send_line(15, 0, 0);
    chk(wr_cnt == 0, "R11 no field accepted", wr_cnt, 0);
    chk(rd_cnt == LW, "R11 line drained", rd_cnt, LW);

    // R1: a partial line is not read.
    start_field(1'b0);
    clear_mon();
    for (int c = 0; c < LW - 1; c++) push_word(pix(14, 0, 0, c));
    repeat (12) @(negedge clk);
    chk(rd_cnt == 0, "R1 partial line held", rd_cnt, 0);
    push_word(pix(14, 0, 0, LW - 1));
    repeat (LW + 6) @(negedge clk);
    // R2: exactly LW reads, back to back
    chk(rd_cnt == LW, "R2 read count", rd_cnt, LW);
    chk(last_rd_cyc - first_rd_cyc == LW - 1, "R2 contiguous reads",
        last_rd_cyc - first_rd_cyc, LW - 1);
    chk(row_errors(14, 0, 0) == 0, "R3 R5 first odd row", row_errors(14, 0, 0), 0);

    // Vector table walk.
    for (int v = 0; v < 9; v++) begin
      int ev, nl, kept, dn;
      ev = int'(VEC[v][7]);
      nl = int'(VEC[v][6:4]);
      kept = int'(VEC[v][3:1]);
      dn = int'(VEC[v][0]);
      start_field(VEC[v][7]);
      clear_mon();
      for (int ln = 0; ln < nl; ln++) send_line(v, ev, ln);
      chk(rd_cnt == nl * LW, "R7 R8 lines drained", rd_cnt, nl * LW);
      chk(wr_cnt == kept * LW, "R7 R8 R9 write count", wr_cnt, kept * LW);
      chk(done_cnt == dn, "R6 R9 frame done count", done_cnt, dn);
      if (kept > 0) begin
        int e = 0;
        for (int ln = 0; ln < kept; ln++) e += row_errors(v, ev, ln);
        chk(e == 0, ev ? "R4 R5 even rows" : "R3 R5 odd rows", e, 0);
        chk(first_addr == ev * LW, "R3 R4 first address", first_addr, ev * LW);
      end
      if (dn == 1)
        chk(done_cyc == last_we_cyc + 1, "R6 done timing", done_cyc - last_we_cyc, 1);
    end

    // R10: an even field start during the last odd line is deferred.
    start_field(1'b0);
    clear_mon();
    for (int ln = 0; ln < FL - 1; ln++) send_line(12, 0, ln);
    for (int c = 0; c < LW; c++) push_word(pix(12, 0, FL - 1, c));
    repeat (5) @(negedge clk);
    field_start = 1'b1;
    field_even = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    repeat (LW + 6) @(negedge clk);
    chk(row_errors(12, 0, FL - 1) == 0, "R10 last odd row kept",
        row_errors(12, 0, FL - 1), 0);
    for (int ln = 0; ln < FL; ln++) send_line(13, 1, ln);
    chk(done_cnt == 1, "R10 deferred even accepted", done_cnt, 1);
    begin
      int e = 0;
      for (int ln = 0; ln < FL; ln++) e += row_errors(13, 1, ln);
      chk(e == 0, "R10 R4 even rows after defer", e, 0);
    end
    chk(wr_cnt == 2 * FL * LW, "R10 total writes", wr_cnt, 2 * FL * LW);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule